// File: doc/BRIEF.md
# Five-Segment Battery Charge Bar Driver

This block turns a battery charge count into a five-segment LED bar. Each lit segment stands for one fifth of a full reference. The reference is either the learned capacity or the programmed full count, chosen by a mode pin. Before it is compared, the displayed charge is scaled down at cold temperatures. The step from full scale to three-quarter scale has hysteresis, so the bar does not flicker near freezing.

The bar lights for a fixed window after a falling edge on the push button. It also lights while charge counting runs above the display rate, and while fast discharge lasts. A strap input keeps it dark. Segments are scanned in two banks: segments 1, 3 and 5 form one bank, segments 2 and 4 the other. Segment 1 blinks when the battery is low. A test override byte can drive every segment directly.

All timing comes from a single-cycle tick input at `TICK_HZ` ticks per second.

Top module: `led_bar_ctrl`

## Requirements
- R1: In relative mode (`abs_mode_i`=0) the reference R is `lmd_i`. In absolute mode it is `pfc_i`. Segment k (k=1..5, driven on `seg_no_o[k-1]`) is lit in its scan slot when the displayed charge D satisfies D >= floor((k-1)*R/5)+1.
- R2: In absolute mode, D is capped at `lmd_i`. Segments whose threshold is above the learned capacity therefore stay dark.
- R3: Temperature step codes on `temp_i` are 0..12, in 10°C steps, with 4 meaning 0..10°C. The scale depends on a temperature band. Warm band: D = nac. Cool band (codes 2..3): D = floor(3*nac/4). Cold band (codes 0..1): D = floor(nac/2).
- R4: A code of 4 keeps the previous band if that band was cool or cold; a cold band moves to cool. Only a code of 5 or more returns to the warm band.
- R5: A falling edge on `btn_ni` opens a display window of 4*`TICK_HZ` ticks. This is 4 s at the nominal tick rate.
- R6: `disp_dis_i`=1 forces all segments dark unless the override is enabled.
- R7: With the strap released, the bar is shown while `chg_disp_i` or `fdis_i` is high or a button window is open. Otherwise it is dark.
- R8: Banks alternate every `TICK_HZ`/320 ticks. Each bank is lit for the first 30% of its slot. The two banks are never lit in the same cycle.
- R9: When `edv_i`=1, or when 10*D < R, segment 1 blinks. Its half period is `TICK_HZ`/8 ticks, which gives 4 Hz. Otherwise segment 1 follows R1.
- R10: When `ovr_i[0]`=1, segment k is lit exactly when `ovr_i[k]`=1, for k=1..5. This overrides scanning, the strap and all display conditions.
- R11: During and right after reset, all `seg_no_o` bits are 1, meaning dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle time-base pulse |
| nac_i | input | CNT_W | Available charge count |
| lmd_i | input | CNT_W | Learned capacity |
| pfc_i | input | CNT_W | Programmed full count |
| abs_mode_i | input | 1 | 1 = absolute reference |
| temp_i | input | 4 | Temperature step code |
| btn_ni | input | 1 | Push-button request, active low |
| disp_dis_i | input | 1 | Display-disable strap |
| chg_disp_i | input | 1 | Charge counting above display rate |
| fdis_i | input | 1 | Fast discharge counting |
| edv_i | input | 1 | End-of-discharge flag |
| ovr_i | input | 6 | Test override: bit 0 enable, bits 5..1 segments |
| seg_no_o | output | 5 | Segment drives, active low |

## Verification
The bench builds the block with `TICK_HZ`=3200 and `tick_i` held high. This gives a 10-tick scan slot, 3 lit ticks per slot, a 400-tick blink half period and a 12800-tick button window. With these values, exact per-segment lit counts fall on 200- and 800-cycle windows. The ±0.5 s edges of the button window are also reachable in a short run. Random charge, capacity, mode and temperature sets are checked against a bench model of thresholds, capping and band hysteresis. Directed cases probe threshold plus-one, the 10% low boundary and each band transition.

// File: rtl/led_bar_pkg.sv
package led_bar_pkg;
  localparam int unsigned NSEG = 5;

  typedef enum logic [1:0] {
    BAND_WARM = 2'd0,
    BAND_COOL = 2'd1,
    BAND_COLD = 2'd2
  } band_e;

  localparam logic [NSEG-1:0] BANK_ODD  = 5'b10101;
  localparam logic [NSEG-1:0] BANK_EVEN = 5'b01010;
endpackage

// File: rtl/led_bar_level.sv
module led_bar_level
  import led_bar_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] nac_i,
  input  logic [CNT_W-1:0] lmd_i,
  input  logic [CNT_W-1:0] pfc_i,
  input  logic             abs_mode_i,
  input  logic [3:0]       temp_i,
  input  logic             edv_i,
  input  logic             blink_i,
  output logic [NSEG-1:0]  lit_o
);
  localparam int unsigned W = CNT_W + 4;

  band_e band_q, band_d;
  logic [W-1:0] nac_w, lmd_w, ref_w, scaled, eff;
  logic [NSEG-1:0] lvl;
  logic low;

  always_comb begin
    if (temp_i <= 4'd1)                          band_d = BAND_COLD;
    else if (temp_i <= 4'd3)                     band_d = BAND_COOL;
    else if (temp_i == 4'd4 && band_q != BAND_WARM) band_d = BAND_COOL;
    else                                         band_d = BAND_WARM;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) band_q <= BAND_WARM;
    else         band_q <= band_d;
  end

  assign nac_w = W'(nac_i);
  assign lmd_w = W'(lmd_i);
  assign ref_w = abs_mode_i ? W'(pfc_i) : lmd_w;

  always_comb begin
    unique case (band_q)
      BAND_COOL: scaled = (W'(3) * nac_w) >> 2;
      BAND_COLD: scaled = nac_w >> 1;
      default:   scaled = nac_w;
    endcase
  end

  // absolute mode never shows more than the learned capacity
  assign eff = (abs_mode_i && scaled > lmd_w) ? lmd_w : scaled;

  for (genvar k = 0; k < NSEG; k++) begin : g_thr
    logic [W-1:0] thr;
    assign thr    = (W'(k) * ref_w) / W'(5) + W'(1);
    assign lvl[k] = eff >= thr;
  end

  assign low   = edv_i || ((W'(10) * eff) < ref_w);
  assign lit_o = {lvl[NSEG-1:1], low ? blink_i : lvl[0]};
endmodule

// File: rtl/led_bar_window.sv
module led_bar_window #(
  parameter int unsigned WIN_TICKS = 128000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic btn_ni,
  output logic win_o
);
  localparam int unsigned WW = $clog2(WIN_TICKS + 1);

  logic          btn_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      btn_q <= btn_ni;
      if (btn_q && !btn_ni)          cnt_q <= WW'(WIN_TICKS);
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - WW'(1);
    end
  end

  assign win_o = cnt_q != '0;
endmodule

// File: rtl/led_bar_scan.sv
module led_bar_scan #(
  parameter int unsigned MUX_PER    = 100,
  parameter int unsigned MUX_ON     = 30,
  parameter int unsigned BLINK_HALF = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic bank_o,
  output logic bank_on_o,
  output logic blink_o
);
  localparam int unsigned PW = (MUX_PER > 1) ? $clog2(MUX_PER) : 1;
  localparam int unsigned BW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  logic [PW-1:0] ph_q;
  logic [BW-1:0] bl_q;
  logic          bank_q, blink_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      bank_q  <= 1'b0;
      bl_q    <= '0;
      blink_q <= 1'b0;
    end else if (tick_i) begin
      if (ph_q == PW'(MUX_PER - 1)) begin
        ph_q   <= '0;
        bank_q <= ~bank_q;
      end else begin
        ph_q <= ph_q + PW'(1);
      end
      if (bl_q == BW'(BLINK_HALF - 1)) begin
        bl_q    <= '0;
        blink_q <= ~blink_q;
      end else begin
        bl_q <= bl_q + BW'(1);
      end
    end
  end

  assign bank_o    = bank_q;
  assign bank_on_o = ph_q < PW'(MUX_ON);
  assign blink_o   = blink_q;
endmodule

// File: rtl/led_bar_ctrl.sv
module led_bar_ctrl
  import led_bar_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TICK_HZ = 32000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] nac_i,
  input  logic [CNT_W-1:0] lmd_i,
  input  logic [CNT_W-1:0] pfc_i,
  input  logic             abs_mode_i,
  input  logic [3:0]       temp_i,
  input  logic             btn_ni,
  input  logic             disp_dis_i,
  input  logic             chg_disp_i,
  input  logic             fdis_i,
  input  logic             edv_i,
  input  logic [5:0]       ovr_i,
  output logic [4:0]       seg_no_o
);
  localparam int unsigned WIN_TICKS  = 4 * TICK_HZ;
  localparam int unsigned MUX_PER    = TICK_HZ / 320;
  localparam int unsigned MUX_ON     = (MUX_PER * 3) / 10;
  localparam int unsigned BLINK_HALF = TICK_HZ / 8;

  logic [NSEG-1:0] lvl_lit, bank_mask, lit;
  logic win_on, disp_on, bank, bank_on, blink;

  led_bar_level #(.CNT_W(CNT_W)) u_level (
    .clk_i, .rst_ni, .nac_i, .lmd_i, .pfc_i, .abs_mode_i, .temp_i, .edv_i,
    .blink_i (blink),
    .lit_o   (lvl_lit)
  );

  led_bar_window #(.WIN_TICKS(WIN_TICKS)) u_window (
    .clk_i, .rst_ni, .tick_i, .btn_ni,
    .win_o (win_on)
  );

  led_bar_scan #(
    .MUX_PER(MUX_PER), .MUX_ON(MUX_ON), .BLINK_HALF(BLINK_HALF)
  ) u_scan (
    .clk_i, .rst_ni, .tick_i,
    .bank_o    (bank),
    .bank_on_o (bank_on),
    .blink_o   (blink)
  );

  assign disp_on   = win_on | chg_disp_i | fdis_i;
  assign bank_mask = !bank_on ? '0 : (bank ? BANK_EVEN : BANK_ODD);

  always_comb begin
    if (ovr_i[0])                     lit = ovr_i[5:1];
    else if (disp_dis_i || !disp_on)  lit = '0;
    else                              lit = lvl_lit & bank_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_no_o <= '1;
    else         seg_no_o <= ~lit;
  end
endmodule

// File: rtl/led_bar_ctrl_chk.sv
module led_bar_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       btn_ni,
  input logic       disp_dis_i,
  input logic [5:0] ovr_i,
  input logic [4:0] seg_no_o,
  input logic       disp_on_i,
  input logic       win_on_i
);
  logic odd_lit, even_lit;
  assign odd_lit  = !seg_no_o[0] || !seg_no_o[2] || !seg_no_o[4];
  assign even_lit = !seg_no_o[1] || !seg_no_o[3];

  a_r6_strap_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_dis_i && !ovr_i[0]) |=> (seg_no_o == 5'h1F));

  a_r7_dark_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!disp_on_i && !ovr_i[0]) |=> (seg_no_o == 5'h1F));

  a_r8_bank_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_i[0] |=> !(odd_lit && even_lit));

  a_r10_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i[0] |=> (seg_no_o == ~$past(ovr_i[5:1])));

  a_r5_window_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(btn_ni) |=> win_on_i);
endmodule

bind led_bar_ctrl led_bar_ctrl_chk u_chk (
  .clk_i, .rst_ni, .btn_ni, .disp_dis_i, .ovr_i, .seg_no_o,
  .disp_on_i (disp_on),
  .win_on_i  (win_on)
);

// File: tb/led_bar_ctrl_tb_top.sv
module led_bar_ctrl_tb_top;
  localparam int TICK_HZ = 3200;
  localparam int CNT_W   = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic [CNT_W-1:0] nac_i = '0, lmd_i = '0, pfc_i = '0;
  logic abs_mode_i = 1'b0;
  logic [3:0] temp_i = 4'd6;
  logic btn_ni = 1'b1, disp_dis_i = 1'b0, chg_disp_i = 1'b0, fdis_i = 1'b0, edv_i = 1'b0;
  logic [5:0] ovr_i = '0;
  logic [4:0] seg_no_o;

  always #4 clk = ~clk;

  led_bar_ctrl #(.CNT_W(CNT_W), .TICK_HZ(TICK_HZ)) dut_i (
    .clk_i(clk), .rst_ni, .tick_i, .nac_i, .lmd_i, .pfc_i, .abs_mode_i, .temp_i,
    .btn_ni, .disp_dis_i, .chg_disp_i, .fdis_i, .edv_i, .ovr_i, .seg_no_o
  );

  int n_chk = 0, n_fail = 0;
  int lit_cnt[5];
  bit both_seen;
  int band_m = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe(int n);
    for (int k = 0; k < 5; k++) lit_cnt[k] = 0;
    both_seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int k = 0; k < 5; k++) if (!seg_no_o[k]) lit_cnt[k]++;
      if ((!seg_no_o[0] || !seg_no_o[2] || !seg_no_o[4]) && (!seg_no_o[1] || !seg_no_o[3]))
        both_seen = 1;
    end
  endtask

  function automatic int mask_of();
    int m = 0;
    for (int k = 0; k < 5; k++) if (lit_cnt[k] > 0) m |= (1 << k);
    return m;
  endfunction

  task automatic set_temp(int code);
    temp_i = 4'(code);
    if (code <= 1)                      band_m = 2;
    else if (code <= 3)                 band_m = 1;
    else if (code == 4 && band_m != 0)  band_m = 1;
    else                                band_m = 0;
  endtask

  function automatic int eff_of(int nac, int lmd, bit abs_m);
    int s;
    s = (band_m == 0) ? nac : (band_m == 1) ? (3 * nac) / 4 : nac / 2;
    if (abs_m && s > lmd) s = lmd;
    return s;
  endfunction

  function automatic int exp_mask(int nac, int lmd, int pfc, bit abs_m);
    int e, r, m;
    e = eff_of(nac, lmd, abs_m);
    r = abs_m ? pfc : lmd;
    m = 0;
    for (int k = 0; k < 5; k++) if (e >= (k * r) / 5 + 1) m |= (1 << k);
    return m;
  endfunction

  function automatic bit exp_low(int nac, int lmd, int pfc, bit abs_m, bit edv);
    return edv || (10 * eff_of(nac, lmd, abs_m) < (abs_m ? pfc : lmd));
  endfunction

  task automatic apply(int nac, int lmd, int pfc, bit abs_m);
    @(negedge clk);
    nac_i = CNT_W'(nac); lmd_i = CNT_W'(lmd); pfc_i = CNT_W'(pfc); abs_mode_i = abs_m;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    int m, e;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(seg_no_o == 5'h1F, "R11 reset dark", seg_no_o, 31);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(seg_no_o == 5'h1F, "R11 after reset", seg_no_o, 31);

    apply(1000, 1000, 1000, 0);
    observe(40);
    chk(mask_of() == 0, "R7 idle dark", mask_of(), 0);

    chg_disp_i = 1'b1;
    apply(1000, 1000, 1000, 0);
    observe(200);
    for (int k = 0; k < 5; k++) chk(lit_cnt[k] == 30, "R8 duty per segment", lit_cnt[k], 30);
    chk(!both_seen, "R8 banks exclusive", both_seen, 0);

    // R1 threshold plus one
    apply(200, 1000, 0, 0); observe(20);
    chk(mask_of() == 5'b00001, "R1 at 1/5 boundary", mask_of(), 1);
    apply(201, 1000, 0, 0); observe(20);
    chk(mask_of() == 5'b00011, "R1 above 1/5", mask_of(), 3);

    // R2 absolute mode capped at learned capacity
    apply(500, 500, 1000, 1); observe(20);
    chk(mask_of() == 5'b00111, "R2 absolute cap", mask_of(), 7);
    apply(500, 500, 1000, 0); observe(20);
    chk(mask_of() == 5'b11111, "R1 relative full", mask_of(), 31);

    // R3/R4 bands and hysteresis
    apply(1000, 1000, 0, 0);
    set_temp(3); repeat (4) @(negedge clk); observe(20);
    chk(mask_of() == 5'b01111, "R3 cool band", mask_of(), 15);
    set_temp(4); repeat (4) @(negedge clk); observe(20);
    chk(mask_of() == 5'b01111, "R4 hold cool at code 4", mask_of(), 15);
    set_temp(5); repeat (4) @(negedge clk); observe(20);
    chk(mask_of() == 5'b11111, "R4 back to warm", mask_of(), 31);
    set_temp(4); repeat (4) @(negedge clk); observe(20);
    chk(mask_of() == 5'b11111, "R4 warm stays at code 4", mask_of(), 31);
    set_temp(1); repeat (4) @(negedge clk); observe(20);
    chk(mask_of() == 5'b00111, "R3 cold band", mask_of(), 7);
    set_temp(4); repeat (4) @(negedge clk); observe(20);
    chk(mask_of() == 5'b01111, "R4 cold to cool at code 4", mask_of(), 15);
    set_temp(6); repeat (4) @(negedge clk);

    // R9 blink
    edv_i = 1'b1; repeat (2) @(negedge clk); observe(800);
    chk(lit_cnt[0] == 60, "R9 blink on edv", lit_cnt[0], 60);
    chk(lit_cnt[1] == 120, "R9 seg2 solid", lit_cnt[1], 120);
    edv_i = 1'b0;
    apply(99, 1000, 0, 0); observe(800);
    chk(lit_cnt[0] == 60, "R9 blink under 10%", lit_cnt[0], 60);
    apply(100, 1000, 0, 0); observe(800);
    chk(lit_cnt[0] == 120, "R9 solid at 10%", lit_cnt[0], 120);

    // R6 strap, R10 override
    apply(1000, 1000, 0, 0);
    disp_dis_i = 1'b1; repeat (2) @(negedge clk); observe(40);
    chk(mask_of() == 0, "R6 strap dark", mask_of(), 0);
    ovr_i = 6'b101011; repeat (2) @(negedge clk); observe(40);
    chk(lit_cnt[0] == 40 && lit_cnt[2] == 40 && lit_cnt[4] == 40 && mask_of() == 5'b10101,
        "R10 override", mask_of(), 21);
    ovr_i = 6'b010100; repeat (2) @(negedge clk); observe(40);
    chk(mask_of() == 0, "R10 override disabled", mask_of(), 0);
    ovr_i = '0; disp_dis_i = 1'b0;

    // R7 fast discharge
    chg_disp_i = 1'b0; fdis_i = 1'b1; repeat (2) @(negedge clk); observe(20);
    chk(mask_of() == 5'b11111, "R7 fast discharge on", mask_of(), 31);
    fdis_i = 1'b0; repeat (2) @(negedge clk); observe(40);
    chk(mask_of() == 0, "R7 fast discharge off", mask_of(), 0);

    // R5 button window
    btn_ni = 1'b0;
    repeat (11300) @(negedge clk);
    observe(200);
    chk(mask_of() == 5'b11111, "R5 window at 3.5s", mask_of(), 31);
    repeat (3000) @(negedge clk);
    observe(200);
    chk(mask_of() == 0, "R5 window closed by 4.5s", mask_of(), 0);
    btn_ni = 1'b1;

    // random sets, R1 R2 R3 R4
    chg_disp_i = 1'b1;
    for (int it = 0; it < 40; it++) begin
      int nac, lmd, pfc; bit am;
      nac = $urandom % 2000; lmd = 500 + $urandom % 1500;
      pfc = 500 + $urandom % 1500; am = 1'($urandom % 2);
      set_temp($urandom % 13);
      apply(nac, lmd, pfc, am);
      observe(20);
      m = mask_of();
      e = exp_mask(nac, lmd, pfc, am);
      if (exp_low(nac, lmd, pfc, am, 0)) begin
        m &= 5'b11110; e &= 5'b11110;
      end
      chk(m == e, "R1 R2 R3 random set", m, e);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule